// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a small binary counter that steps up or down by one on each rising clock edge. A level-sensitive load input, active low, presets the count from a data bus with no clock needed, and it takes precedence over counting. An active-low enable gates the counting. A direction input selects whether the counter increments or decrements, and the count wraps at both ends of its range.

The stage decodes a terminal-count flag whose meaning depends on the direction. The flag marks the all-ones value when counting up and zero when counting down, and the enable has no effect on it. A ripple-clock output reuses the clock's low phase whenever the stage sits at terminal count and is enabled. It idles high at all other times. Its rising edge can clock the next stage of a longer counter, or it can serve as that stage's enable.

Top module: `updown_stage`

## Requirements
- R1: While `load_n` is low, `count` equals `din` at once, with no clock edge required.
- R2: While `load_n` is low, rising clock edges do not change `count` away from `din`, whatever the values of `en_n` and `down`. After `load_n` rises, counting continues from the loaded value.
- R3: With `load_n` high and `en_n` high (1 = hold), a rising clock edge leaves `count` unchanged.
- R4: With `load_n` high, `en_n` low and `down` low (0 = up), each rising clock edge adds one to `count`, and the all-ones value wraps to 0.
- R5: With `load_n` high, `en_n` low and `down` high (1 = down), each rising clock edge subtracts one from `count`, and 0 wraps to all ones.
- R6: `tc` is 1 exactly when `down` is 0 and `count` is all ones, or when `down` is 1 and `count` is 0. A change of `count` or of `down` updates `tc` without waiting for a clock edge.
- R7: `tc` does not depend on `en_n`.
- R8: `rc` equals `clk` while `tc` is 1 and `en_n` is 0. Otherwise `rc` is 1. In particular, `rc` is low only during the clock-low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, active on the rising edge |
| load_n | input | 1 | Asynchronous preset, active low |
| en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| tc | output | 1 | Direction-aware terminal count |
| rc | output | 1 | Gated ripple clock, idles high |

## Verification
The count changes in the same cycle as the rising clock edge that causes it: there is one register, and nothing follows it except decoding. Loading, `tc` and `rc` have no register in their path, so they respond within the same time step as the input change. Each bench cycle drives its inputs shortly after the falling edge. It samples every output during the low phase, before the next rising edge, and again during the high phase after that edge. This checks the asynchronous paths and the clocked update at separate points and never at an edge.

// File: rtl/updown_stage.sv
module updown_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_n,
  input  logic             down,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             tc,
  output logic             rc
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] next_val;

  assign next_val = down ? state_q - ONE : state_q + ONE;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)    state_q <= din;
    else if (!en_n) state_q <= next_val;
  end

  assign count = load_n ? state_q : din;
  assign tc    = down ? (count == '0) : (count == TOP);
  assign rc    = ~(tc & ~en_n & ~clk);

  logic [1:0] armed_q;
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) armed_q <= 2'b00;
    else         armed_q <= {armed_q[0], 1'b1};
  end

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (!load_n)
    (armed_q[1] && $past(en_n)) |-> (count == $past(count)));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!load_n)
    (armed_q[1] && !$past(en_n) && !$past(down)) |-> (count == $past(count) + ONE));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!load_n)
    (armed_q[1] && !$past(en_n) && $past(down)) |-> (count == $past(count) - ONE));

  // R8
  rc_high_phase_chk: assert property (@(negedge clk) disable iff (!load_n)
    rc);

  // R8
  rc_low_pulse_chk: assert property (@(posedge clk) disable iff (!load_n)
    (tc && !en_n) |-> !rc);
endmodule

// File: tb/tb_updown_stage.sv
`timescale 1ns/1ps
module tb_updown_stage;
  localparam int WIDTH = 4;
  localparam int MAXV  = (1 << WIDTH) - 1;

  logic clk = 1'b0;
  logic load_n = 1'b0;
  logic en_n = 1'b1;
  logic down = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] count;
  logic tc, rc;

  int compared = 0;
  int mismatched = 0;
  int model = 0;
  bit finished = 0;

  updown_stage #(.WIDTH(WIDTH)) dut (
    .clk(clk), .load_n(load_n), .en_n(en_n), .down(down),
    .din(din), .count(count), .tc(tc), .rc(rc)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  function automatic int exp_tc(input int v, input bit dn);
    return dn ? int'(v == 0) : int'(v == MAXV);
  endfunction

  // One clock period: inputs at +1 (low phase), checks at +3 (low) and +8 (high).
  task automatic cycle(input bit ld, input bit en, input bit dn, input int d);
    load_n = ld; en_n = en; down = dn; din = WIDTH'(d);
    if (!ld) model = d;
    #2;
    check(ld ? "R6" : "R1", "count low phase", int'(count), model);
    check(en ? "R7" : "R6", "tc low phase", int'(tc), exp_tc(model, dn));
    check("R8", "rc low phase", int'(rc), (exp_tc(model, dn) == 1 && !en) ? 0 : 1);
    #5;
    if (!ld) model = d;
    else if (!en) model = dn ? (model + MAXV) % (MAXV + 1) : (model + 1) % (MAXV + 1);
    check(!ld ? "R2" : (en ? "R3" : (dn ? "R5" : "R4")), "count high phase", int'(count), model);
    check("R6", "tc high phase", int'(tc), exp_tc(model, dn));
    check("R8", "rc high phase", int'(rc), 1);
    #3;
  endtask

  initial begin
    #1;
    check("R1", "count in reset", int'(count), 0);
    #10;
    for (int v = 0; v <= MAXV; v++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int en = 0; en < 2; en++) begin
          cycle(1'b0, 1'b0, dn[0], v);
          cycle(1'b1, en[0], dn[0], (v + 5) % (MAXV + 1));
          for (int k = 0; k < MAXV + 2; k++) cycle(1'b1, en[0], dn[0], k);
          cycle(1'b1, en[0], ~dn[0], 0);
        end
      end
    end
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom);
      cycle((r % 9) != 0, r[4], r[5], (r >> 8) & MAXV);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule